// File: doc/BRIEF.md
# Graphic Equalizer Serial Control Receiver

This block is the digital control side of a stereo graphic equalizer with seven bands per channel. A host drives three wires: a serial clock, a serial data line and a strobe. Bits enter an eight-bit shift register on serial clock rising edges, least significant bit first. A strobe pulse then commits the assembled word. The word's top bit decides its meaning. It either picks a band and sets the range of both channels, or it loads a boost or cut setting into the band picked earlier.

All three wires are sampled by a faster system clock through synchronizers, and their edges are detected in that domain. The block keeps the selected band, one range flag per channel and a stored gain for each of the fourteen bands. For each band it drives a signed dB figure and the tap-switch pattern that sets the analog resistor network. It also drives a direction bit that marks boost.

Top module: `eq_ctrl_rx`

## Requirements
- R1: Serial data is captured on each rising edge of `ser_clk`, least significant bit first. On a rising edge of `ser_stb`, the last eight bits shifted in are taken as the word, with the first bit shifted becoming bit 0.
- R2: A word with bit 7 = 1 is a band word. Bit 5 = 1 puts channel A (bands 1–7) in the half range (±6 dB), and bit 5 = 0 puts it in the full range (±12 dB). Bit 4 does the same for channel B (bands 8–14). Bit 6 has no effect.
- R3: In a band word, bits 3..0 = 1..14 select that band and drive it on `sel_band`. Codes 0 and 15 select no band, and `sel_band` reads 0.
- R4: A word with bit 7 = 0 is a gain word. It updates only the currently selected band. It leaves every other band unchanged, and the selection stays in place for further gain words.
- R5: In a gain word, bit 6 = 1 means boost and bit 6 = 0 means cut. The magnitude comes from bits 5..0: 000000 = 0 dB (flat), 100000 = 1, 010000 = 2, 001000 = 3, 000100 = 4, 000010 = 5, 010010 = 6, 101010 = 7, 010110 = 8, 000001 = 9, 101001 = 10, 101101 = 11, 101111 = 12.
- R6: A gain word whose bits 5..0 match no entry of the R5 table changes nothing.
- R7: A gain word received while no band is selected changes nothing.
- R8: `band_db` for band b (bits 5b+4..5b, two's complement) is +magnitude for boost and −magnitude for cut. The magnitude is halved and rounded toward zero while the band's channel is in the half range.
- R9: `band_taps` for band b (bits 6b+5..6b) carries the R5 code of the stored magnitude, and `band_boost[b]` carries the direction. A flat band drives all of its tap bits and its direction bit to 0.
- R10: While `rst_n` is low, all bands become flat, both channels go to the full range and no band is selected.
- R11: Serial clock edges with no strobe change neither the selection, the ranges nor any stored gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_stb | input | 1 | Strobe that commits the shifted word, asynchronous |
| band_db | output | 70 | Signed dB per band, 5 bits each, band 1 in the lowest bits |
| band_taps | output | 84 | Tap-switch pattern per band, 6 bits each |
| band_boost | output | 14 | Direction per band, 1 = boost, 0 when flat |
| sel_band | output | 4 | Selected band 1..14, 0 when none |
| range6_a | output | 1 | Channel A in half range |
| range6_b | output | 1 | Channel B in half range |

## Verification
The assertions check several things on every cycle. A band with no tap closed never reports a nonzero dB figure. The selection never leaves 0..14. Stored state only moves on a strobe edge. A gain word can touch no band other than the selected one, and it touches nothing when the code is invalid or no band is selected. Other behaviour only the bench's scenarios can show: least-significant-first assembly, the exact irregular code table, halving with rounding toward zero, bit 6 being ignored in band words, and gain words continuing to reach a band that was selected several words earlier.

// File: rtl/eq_ctrl_rx.sv
module eq_ctrl_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_clk,
  input  logic         ser_data,
  input  logic         ser_stb,
  output logic [69:0]  band_db,
  output logic [83:0]  band_taps,
  output logic [13:0]  band_boost,
  output logic [3:0]   sel_band,
  output logic         range6_a,
  output logic         range6_b
);
  localparam int NB     = 14;
  localparam int PER_CH = NB / 2;

  function automatic logic [4:0] dec_gain(input logic [5:0] c);
    case (c)
      6'b000000: return {1'b1, 4'd0};
      6'b100000: return {1'b1, 4'd1};
      6'b010000: return {1'b1, 4'd2};
      6'b001000: return {1'b1, 4'd3};
      6'b000100: return {1'b1, 4'd4};
      6'b000010: return {1'b1, 4'd5};
      6'b010010: return {1'b1, 4'd6};
      6'b101010: return {1'b1, 4'd7};
      6'b010110: return {1'b1, 4'd8};
      6'b000001: return {1'b1, 4'd9};
      6'b101001: return {1'b1, 4'd10};
      6'b101101: return {1'b1, 4'd11};
      6'b101111: return {1'b1, 4'd12};
      default:   return {1'b0, 4'd0};
    endcase
  endfunction

  function automatic logic [5:0] enc_taps(input logic [3:0] m);
    case (m)
      4'd1:    return 6'b100000;
      4'd2:    return 6'b010000;
      4'd3:    return 6'b001000;
      4'd4:    return 6'b000100;
      4'd5:    return 6'b000010;
      4'd6:    return 6'b010010;
      4'd7:    return 6'b101010;
      4'd8:    return 6'b010110;
      4'd9:    return 6'b000001;
      4'd10:   return 6'b101001;
      4'd11:   return 6'b101101;
      4'd12:   return 6'b101111;
      default: return 6'b000000;
    endcase
  endfunction

  logic [SYNC_STAGES:0] ck_s, dt_s, sb_s;
  logic [WORD_W-1:0]    shreg;
  logic [NB-1:0][4:0]   gst;
  logic [3:0]           sel_q;
  logic                 rng_a, rng_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_s <= '0;
      dt_s <= '0;
      sb_s <= '0;
    end else begin
      ck_s <= {ck_s[SYNC_STAGES-1:0], ser_clk};
      dt_s <= {dt_s[SYNC_STAGES-1:0], ser_data};
      sb_s <= {sb_s[SYNC_STAGES-1:0], ser_stb};
    end
  end

  wire ck_rise  = ck_s[SYNC_STAGES-1] & ~ck_s[SYNC_STAGES];
  wire stb_rise = sb_s[SYNC_STAGES-1] & ~sb_s[SYNC_STAGES];
  wire bit_in   = dt_s[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else if (ck_rise) shreg <= {bit_in, shreg[WORD_W-1:1]};
  end

  wire       is_band = shreg[7];
  wire [4:0] gdec    = dec_gain(shreg[5:0]);
  wire       g_ok    = gdec[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gst   <= '0;
      sel_q <= '0;
      rng_a <= 1'b0;
      rng_b <= 1'b0;
    end else if (stb_rise) begin
      if (is_band) begin
        rng_a <= shreg[5];
        rng_b <= shreg[4];
        sel_q <= (shreg[3:0] == 4'hF) ? 4'h0 : shreg[3:0];
      end else if (g_ok) begin
        for (int b = 0; b < NB; b++)
          if (sel_q == 4'(b + 1)) gst[b] <= {shreg[6], gdec[3:0]};
      end
    end
  end

  assign sel_band = sel_q;
  assign range6_a = rng_a;
  assign range6_b = rng_b;

  for (genvar b = 0; b < NB; b++) begin : g_band
    wire [3:0] mag  = gst[b][3:0];
    wire       half = (b < PER_CH) ? rng_a : rng_b;
    wire [3:0] shown = half ? (mag >> 1) : mag;
    assign band_db[b*5 +: 5]   = gst[b][4] ? {1'b0, shown} : -{1'b0, shown};
    assign band_taps[b*6 +: 6] = enc_taps(mag);
    assign band_boost[b]       = (mag != 4'd0) & gst[b][4];

    a_r9_flat_open: assert property (@(posedge clk) disable iff (!rst_n)
      (band_taps[b*6 +: 6] == 6'd0) |-> (band_db[b*5 +: 5] == 5'd0 && !band_boost[b]));
    a_r4_other_bands_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_rise && !is_band && sel_q != 4'(b + 1)) |=> $stable(gst[b]));
  end

  a_r3_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q <= 4'd14);
  a_r11_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_rise |=> ($stable(gst) && $stable(sel_q) && $stable(rng_a) && $stable(rng_b)));
  a_r6_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && !is_band && !g_ok) |=> $stable(gst));
  a_r7_no_band_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && !is_band && sel_q == 4'd0) |=> $stable(gst));
endmodule

// File: tb/eq_ctrl_rx_tb.sv
module eq_ctrl_rx_tb_top;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_data = 0, ser_stb = 0;
  logic [69:0] band_db;
  logic [83:0] band_taps;
  logic [13:0] band_boost;
  logic [3:0]  sel_band;
  logic        range6_a, range6_b;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eq_ctrl_rx dut_i (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_stb(ser_stb), .band_db(band_db), .band_taps(band_taps), .band_boost(band_boost),
    .sel_band(sel_band), .range6_a(range6_a), .range6_b(range6_b));

  // {word, band index, expected dB, expected taps, expected selection}
  localparam logic [26:0] VEC [23] = '{
    {8'h83, 4'd2,  5'd0,  6'b000000, 4'd3},
    {8'h42, 4'd2,  5'd5,  6'b000010, 4'd3},
    {8'h2F, 4'd2,  5'h14, 6'b101111, 4'd3},
    {8'h99, 4'd8,  5'd0,  6'b000000, 4'd9},
    {8'h6A, 4'd8,  5'd3,  6'b101010, 4'd9},
    {8'h01, 4'd8,  5'h1C, 6'b000001, 4'd9},
    {8'h83, 4'd2,  5'h14, 6'b101111, 4'd3},
    {8'hC3, 4'd2,  5'h14, 6'b101111, 4'd3},
    {8'h43, 4'd2,  5'h14, 6'b101111, 4'd3},
    {8'h40, 4'd2,  5'd0,  6'b000000, 4'd3},
    {8'h80, 4'd8,  5'h17, 6'b000001, 4'd0},
    {8'h6F, 4'd8,  5'h17, 6'b000001, 4'd0},
    {8'hAF, 4'd2,  5'd0,  6'b000000, 4'd0},
    {8'hA1, 4'd0,  5'd0,  6'b000000, 4'd1},
    {8'h6D, 4'd0,  5'd5,  6'b101101, 4'd1},
    {8'h20, 4'd0,  5'd0,  6'b100000, 4'd1},
    {8'h8E, 4'd13, 5'd0,  6'b000000, 4'd14},
    {8'h52, 4'd13, 5'd6,  6'b010010, 4'd14},
    {8'h56, 4'd13, 5'd8,  6'b010110, 4'd14},
    {8'h69, 4'd13, 5'd10, 6'b101001, 4'd14},
    {8'h50, 4'd13, 5'd2,  6'b010000, 4'd14},
    {8'h48, 4'd13, 5'd3,  6'b001000, 4'd14},
    {8'h44, 4'd13, 5'd4,  6'b000100, 4'd14}
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_word(logic [7:0] w);
    for (int i = 0; i < 8; i++) begin
      ser_data = w[i];
      wait_clk(3);
      ser_clk = 1;
      wait_clk(3);
      ser_clk = 0;
    end
  endtask

  task automatic strobe();
    wait_clk(3);
    ser_stb = 1;
    wait_clk(3);
    ser_stb = 0;
    wait_clk(6);
  endtask

  function automatic int db_of(int b);
    return int'($signed(band_db[b*5 +: 5]));
  endfunction

  initial begin
    wait_clk(4);
    chk("R10 reset sel", int'(sel_band), 0);
    chk("R10 reset taps", int'(band_taps != 0), 0);
    chk("R10 reset db", int'(band_db != 0), 0);
    chk("R10 reset ranges", int'({range6_a, range6_b}), 0);
    rst_n = 1;
    wait_clk(2);

    for (int v = 0; v < 23; v++) begin
      logic [7:0] w;
      int idx;
      w   = VEC[v][26:19];
      idx = int'(VEC[v][18:15]);
      shift_word(w);
      strobe();
      chk($sformatf("R1 R5 R8 vec%0d db", v), db_of(idx), int'($signed(VEC[v][14:10])));
      chk($sformatf("R9 vec%0d taps", v), int'(band_taps[idx*6 +: 6]), int'(VEC[v][9:4]));
      chk($sformatf("R3 R4 vec%0d sel", v), int'(sel_band), int'(VEC[v][3:0]));
    end

    // R11: shifting without a strobe leaves all state alone
    shift_word(8'h81);
    wait_clk(6);
    chk("R11 sel held", int'(sel_band), 14);
    chk("R11 band14 held", db_of(13), 4);

    // R2: both channels to half range, no band
    shift_word(8'hB0);
    strobe();
    chk("R2 range A", int'(range6_a), 1);
    chk("R2 range B", int'(range6_b), 1);
    chk("R3 none selected", int'(sel_band), 0);
    chk("R8 band14 halved", db_of(13), 2);
    chk("R8 band1 cut 1 halved", db_of(0), 0);
    chk("R9 band1 taps", int'(band_taps[5:0]), 32);
    chk("R9 band1 cut dir", int'(band_boost[0]), 0);
    chk("R9 band14 boost dir", int'(band_boost[13]), 1);
    chk("R9 flat band3 dir", int'(band_boost[2]), 0);

    rst_n = 0;
    wait_clk(3);
    rst_n = 1;
    wait_clk(1);
    chk("R10 reset clears db", int'(band_db != 0), 0);
    chk("R10 reset clears taps", int'(band_taps != 0), 0);
    chk("R10 reset clears dir", int'(band_boost), 0);
    chk("R10 reset ranges", int'({range6_a, range6_b}), 0);
    chk("R10 reset sel", int'(sel_band), 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(negedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule